// File: doc/BRIEF.md
# Pixel Unpack and Composite Selector

This block sits at the front of a video output path. Once per input clock it takes a wide pixel-port word together with per-slot pixel-select bits, per-slot 2-bit overlay codes and an active-low blank. The word holds between two and five pixel slots. The block then emits one pixel per dot clock, in slot order. Each pixel is read as 8-bit pseudo-colour, 16-bit packed RGB, or 32-bit RGB combined with a pseudo byte. For every pixel the block produces three 8-bit lookup indices and a 2-bit select code. The code tells downstream logic which table to use: the RGB tables, the pseudo tables, the overlay table, or forced black.

The word is captured on a load strobe from the input-clock domain, and the dot clock is supplied directly. Several control values are sampled at the same moment as the word: the mode value (pixel size, slots per word and pseudo-byte steering), the pseudo mask, the overlay mask and the compositing mode. Every pixel of a word is therefore decoded under one consistent setting, even if the controls change while the slots are still being emitted.

Top module: `pixsel_unpack`

## Requirements
- R1: Mode bits 4:2 give the number of slots per word. Values below 2 count as 2 and values above 5 count as 5. After a load, valid_o is high for exactly that many consecutive cycles, in slot order 0 upward. When valid_o is low, sel_code_o is 11 and all indices are zero.
- R2: Slot j of a word whose load_i is sampled at clock edge n is on the outputs after edge n+1+j. A load that arrives while slots are still pending abandons the rest of the old word, and the new word's slot 0 follows one edge later.
- R3: Size code 10 (mode bits 1:0) selects 16-bit pixels. Slot k takes port bits 16k+15:16k. Red is taken from bits 15:10 and becomes {r,2'b00}. Green is taken from bits 9:4 and becomes {g,2'b00}. Blue is taken from bits 3:0 and becomes {b,4'b0000}.
- R4: Size code 00 selects 32-bit pixels. Slot k takes port bits 32k+31:32k, with red in 31:24, green in 23:16, blue in 15:8 and pseudo in 7:0. Mode bits 6:5 pick which byte feeds the pseudo path: 00 the pseudo byte, 01 blue, 10 green, 11 red.
- R5: The pseudo value is ANDed with pseudo_mask_i before the zero test, and the masked value is the emitted pseudo index.
- R6: In 32-bit mode, comp_mode_i picks pseudo (otherwise RGB) according to pix_sel_i[k] and the masked pseudo value p. Code 00 picks pseudo when the select bit is high and p is non-zero. Code 01 picks pseudo when p is non-zero. Code 10 picks pseudo when the select bit is high. Code 11 always picks pseudo.
- R7: Size code 01 selects 8-bit pixels. Slot k takes port bits 8k+7:8k, and the pixel always takes the pseudo path. 16-bit pixels always take the RGB path. In both sizes the compositing mode and the select bits have no effect.
- R8: The overlay bits ovl_i[2k+1:2k] are ANDed with ovl_mask_i. A non-zero result v overrides the pixel in every size: the select code becomes 10 and all three indices equal v. A zero result lets the pixel through.
- R9: When blank_n_i is low at load, every slot of that word carries select code 11 with all indices zero. This holds whatever the pixel or overlay values are.
- R10: Size code 11 is reserved. Its slots are valid but carry select code 11 with all indices zero.
- R11: While rst is high, and after it is released, valid_o is 0, sel_code_o is 11 and the indices are zero until the first load.
- R12: Changes to the mode, masks, compositing mode, select bits, overlay bits or blank between loads do not affect the slots of a word already loaded.
- Select codes: 00 RGB, 01 pseudo (all three indices equal the masked pseudo value), 10 overlay, 11 black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Input-clock strobe that captures a word and the controls |
| pix_word_i | input | 160 | Pixel-port word, byte ports 0 to 19 |
| pix_sel_i | input | 5 | Per-slot pixel-select bit |
| ovl_i | input | 10 | Per-slot 2-bit overlay code |
| blank_n_i | input | 1 | Active-low blank for the whole word |
| mode_i | input | 7 | Size [1:0], slots per word [4:2], pseudo steering [6:5] |
| pseudo_mask_i | input | 8 | Pseudo mask |
| ovl_mask_i | input | 2 | Overlay mask |
| comp_mode_i | input | 2 | Compositing mode |
| valid_o | output | 1 | Pixel present this cycle |
| sel_code_o | output | 2 | 00 RGB, 01 pseudo, 10 overlay, 11 black |
| red_idx_o | output | 8 | Red lookup index |
| grn_idx_o | output | 8 | Green lookup index |
| blu_idx_o | output | 8 | Blue lookup index |

## Verification
The hardest case to reach is a load that arrives before the previous word has emitted all its slots. That case requires the abandoned slots to vanish and the new slot 0 to follow one edge later. The stimulus reaches it with loads every two cycles under a four-slot setting, and with random gaps shorter than the slot count. Between loads the bench scrambles every control input, so each word shows that its controls were captured at load. A reference model keyed by edge number predicts every output on every cycle.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

    localparam int FACT_W = 3;

    typedef enum logic [1:0] {
        SEL_RGB    = 2'b00,
        SEL_PSEUDO = 2'b01,
        SEL_OVL    = 2'b10,
        SEL_BLANK  = 2'b11
    } sel_code_e;

    typedef enum logic [1:0] {
        SZ_32  = 2'b00,
        SZ_8   = 2'b01,
        SZ_16  = 2'b10,
        SZ_RSV = 2'b11
    } pix_size_e;

    typedef struct packed {
        logic [1:0]        steer;
        logic [FACT_W-1:0] factor;
        pix_size_e         size;
    } mode_t;

    typedef struct packed {
        mode_t      mode;
        logic [7:0] pmask;
        logic [1:0] omask;
        logic [1:0] comp;
    } cfg_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        sel_code_e sel;
        rgb_t      idx;
    } pix_out_t;

    function automatic logic [FACT_W-1:0] clamp_factor(logic [FACT_W-1:0] f, int unsigned maxs);
        logic [FACT_W-1:0] hi;
        hi = FACT_W'(maxs);
        if (f < FACT_W'(2))
            return FACT_W'(2);
        else if (f > hi)
            return hi;
        else
            return f;
    endfunction

    function automatic rgb_t unpack16(logic [15:0] h);
        rgb_t c;
        c.r = {h[15:10], 2'b00};
        c.g = {h[9:4], 2'b00};
        c.b = {h[3:0], 4'b0000};
        return c;
    endfunction

    function automatic rgb_t unpack32(logic [31:0] w);
        rgb_t c;
        c.r = w[31:24];
        c.g = w[23:16];
        c.b = w[15:8];
        return c;
    endfunction

    function automatic logic [7:0] steer_byte(logic [31:0] w, logic [1:0] steer);
        return w[8*steer +: 8];
    endfunction

    function automatic logic want_pseudo(logic [1:0] comp, logic psel, logic nz);
        case (comp)
            2'b00:   return psel & nz;
            2'b01:   return nz;
            2'b10:   return psel;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pixsel_capture.sv
module pixsel_capture
    import pixsel_pkg::*;
#(
    parameter int MAX_SLOTS = 5,
    localparam int WORD_W = 32 * MAX_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [WORD_W-1:0]    word_i,
    input  logic [MAX_SLOTS-1:0] psel_i,
    input  logic [2*MAX_SLOTS-1:0] ovl_i,
    input  logic                 blank_n_i,
    input  cfg_t                 cfg_i,
    output logic                 live_o,
    output logic [FACT_W-1:0]    slot_o,
    output logic [WORD_W-1:0]    word_o,
    output logic [MAX_SLOTS-1:0] psel_o,
    output logic [2*MAX_SLOTS-1:0] ovl_o,
    output logic                 blank_n_o,
    output cfg_t                 cfg_o
);

    logic [FACT_W-1:0] factor_q;
    logic              last_slot;

    assign last_slot = (slot_o == factor_q - FACT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            live_o    <= 1'b0;
            slot_o    <= '0;
            factor_q  <= FACT_W'(2);
            word_o    <= '0;
            psel_o    <= '0;
            ovl_o     <= '0;
            blank_n_o <= 1'b1;
            cfg_o     <= '0;
        end else if (load_i) begin
            live_o    <= 1'b1;
            slot_o    <= '0;
            factor_q  <= clamp_factor(cfg_i.mode.factor, MAX_SLOTS);
            word_o    <= word_i;
            psel_o    <= psel_i;
            ovl_o     <= ovl_i;
            blank_n_o <= blank_n_i;
            cfg_o     <= cfg_i;
        end else if (live_o) begin
            if (last_slot)
                live_o <= 1'b0;
            else
                slot_o <= slot_o + FACT_W'(1);
        end
    end

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        live_o |-> (slot_o < factor_q && factor_q >= FACT_W'(2) && factor_q <= FACT_W'(MAX_SLOTS)));

    // R1
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (live_o && !load_i && !last_slot) |=> (live_o && slot_o == $past(slot_o) + FACT_W'(1)));

endmodule

// File: rtl/pixsel_slot_pick.sv
module pixsel_slot_pick
    import pixsel_pkg::*;
#(
    parameter int MAX_SLOTS = 5,
    localparam int WORD_W = 32 * MAX_SLOTS
) (
    input  logic [WORD_W-1:0]      word_i,
    input  logic [MAX_SLOTS-1:0]   psel_i,
    input  logic [2*MAX_SLOTS-1:0] ovl_i,
    input  logic [FACT_W-1:0]      slot_i,
    input  pix_size_e              size_i,
    output logic [31:0]            raw_o,
    output logic                   psel_o,
    output logic [1:0]             ovl_o
);

    logic [31:0] cand32 [MAX_SLOTS];
    logic [31:0] cand16 [MAX_SLOTS];
    logic [31:0] cand8  [MAX_SLOTS];

    for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_slot
        assign cand32[k] = word_i[32*k +: 32];
        assign cand16[k] = {16'h0000, word_i[16*k +: 16]};
        assign cand8[k]  = {24'h000000, word_i[8*k +: 8]};
    end

    always_comb begin
        raw_o  = '0;
        psel_o = 1'b0;
        ovl_o  = '0;
        for (int k = 0; k < MAX_SLOTS; k++) begin
            if (slot_i == FACT_W'(k)) begin
                psel_o = psel_i[k];
                ovl_o  = ovl_i[2*k +: 2];
                case (size_i)
                    SZ_16:   raw_o = cand16[k];
                    SZ_8:    raw_o = cand8[k];
                    default: raw_o = cand32[k];
                endcase
            end
        end
    end

endmodule

// File: rtl/pixsel_compose.sv
module pixsel_compose
    import pixsel_pkg::*;
(
    input  logic        live_i,
    input  logic [31:0] raw_i,
    input  logic        psel_i,
    input  logic [1:0]  ovl_i,
    input  logic        blank_n_i,
    input  cfg_t        cfg_i,
    output pix_out_t    pix_o
);

    logic [7:0] pbyte;
    logic [7:0] pval;
    logic [1:0] ovl_hit;
    logic       use_pseudo;

    always_comb begin
        pbyte = (cfg_i.mode.size == SZ_32) ? steer_byte(raw_i, cfg_i.mode.steer) : raw_i[7:0];
        pval  = pbyte & cfg_i.pmask;
        ovl_hit = ovl_i & cfg_i.omask;

        case (cfg_i.mode.size)
            SZ_8:    use_pseudo = 1'b1;
            SZ_16:   use_pseudo = 1'b0;
            default: use_pseudo = want_pseudo(cfg_i.comp, psel_i, pval != 8'h00);
        endcase

        if (!live_i || !blank_n_i || cfg_i.mode.size == SZ_RSV) begin
            pix_o.sel = SEL_BLANK;
            pix_o.idx = '0;
        end else if (ovl_hit != 2'b00) begin
            pix_o.sel = SEL_OVL;
            pix_o.idx = '{r: {6'b0, ovl_hit}, g: {6'b0, ovl_hit}, b: {6'b0, ovl_hit}};
        end else if (use_pseudo) begin
            pix_o.sel = SEL_PSEUDO;
            pix_o.idx = '{r: pval, g: pval, b: pval};
        end else begin
            pix_o.sel = SEL_RGB;
            pix_o.idx = (cfg_i.mode.size == SZ_16) ? unpack16(raw_i[15:0]) : unpack32(raw_i);
        end
    end

endmodule

// File: rtl/pixsel_unpack.sv
module pixsel_unpack
    import pixsel_pkg::*;
#(
    parameter int MAX_SLOTS = 5,
    localparam int WORD_W = 32 * MAX_SLOTS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_i,
    input  logic [WORD_W-1:0]      pix_word_i,
    input  logic [MAX_SLOTS-1:0]   pix_sel_i,
    input  logic [2*MAX_SLOTS-1:0] ovl_i,
    input  logic                   blank_n_i,
    input  logic [6:0]             mode_i,
    input  logic [7:0]             pseudo_mask_i,
    input  logic [1:0]             ovl_mask_i,
    input  logic [1:0]             comp_mode_i,
    output logic                   valid_o,
    output logic [1:0]             sel_code_o,
    output logic [7:0]             red_idx_o,
    output logic [7:0]             grn_idx_o,
    output logic [7:0]             blu_idx_o
);

    cfg_t                   cfg_in;
    cfg_t                   cfg_q;
    logic                   live;
    logic [FACT_W-1:0]      slot;
    logic [WORD_W-1:0]      word_q;
    logic [MAX_SLOTS-1:0]   psel_q;
    logic [2*MAX_SLOTS-1:0] ovl_q;
    logic                   blank_n_q;
    logic [31:0]            raw;
    logic                   psel_cur;
    logic [1:0]             ovl_cur;
    pix_out_t               pix_next;
    pix_out_t               out_q;
    logic                   valid_q;

    assign cfg_in.mode  = mode_t'(mode_i);
    assign cfg_in.pmask = pseudo_mask_i;
    assign cfg_in.omask = ovl_mask_i;
    assign cfg_in.comp  = comp_mode_i;

    pixsel_capture #(.MAX_SLOTS(MAX_SLOTS)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .word_i    (pix_word_i),
        .psel_i    (pix_sel_i),
        .ovl_i     (ovl_i),
        .blank_n_i (blank_n_i),
        .cfg_i     (cfg_in),
        .live_o    (live),
        .slot_o    (slot),
        .word_o    (word_q),
        .psel_o    (psel_q),
        .ovl_o     (ovl_q),
        .blank_n_o (blank_n_q),
        .cfg_o     (cfg_q)
    );

    pixsel_slot_pick #(.MAX_SLOTS(MAX_SLOTS)) u_pick (
        .word_i (word_q),
        .psel_i (psel_q),
        .ovl_i  (ovl_q),
        .slot_i (slot),
        .size_i (cfg_q.mode.size),
        .raw_o  (raw),
        .psel_o (psel_cur),
        .ovl_o  (ovl_cur)
    );

    pixsel_compose u_compose (
        .live_i    (live),
        .raw_i     (raw),
        .psel_i    (psel_cur),
        .ovl_i     (ovl_cur),
        .blank_n_i (blank_n_q),
        .cfg_i     (cfg_q),
        .pix_o     (pix_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            out_q.sel <= SEL_BLANK;
            out_q.idx <= '0;
        end else begin
            valid_q <= live;
            out_q   <= pix_next;
        end
    end

    assign valid_o    = valid_q;
    assign sel_code_o = out_q.sel;
    assign red_idx_o  = out_q.idx.r;
    assign grn_idx_o  = out_q.idx.g;
    assign blu_idx_o  = out_q.idx.b;

    // R9
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q.sel == SEL_BLANK) |-> (out_q.idx == '0));

    // R5
    pseudo_gray_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q.sel == SEL_PSEUDO) |-> (out_q.idx.r == out_q.idx.g && out_q.idx.g == out_q.idx.b));

    // R8
    ovl_code_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q.sel == SEL_OVL) |-> (out_q.idx.r != 8'd0 && out_q.idx.r <= 8'd3
                                    && out_q.idx.r == out_q.idx.g && out_q.idx.g == out_q.idx.b));

    // R1
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (out_q.sel == SEL_BLANK));

    // R2
    first_slot_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> ##2 valid_q);

endmodule

// File: tb/tb_pixsel_unpack.sv
module tb_pixsel_unpack;

    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [159:0]  pix_word_i = '0;
    logic [4:0]    pix_sel_i = '0;
    logic [9:0]    ovl_i = '0;
    logic          blank_n_i = 1'b1;
    logic [6:0]    mode_i = '0;
    logic [7:0]    pseudo_mask_i = '0;
    logic [1:0]    ovl_mask_i = '0;
    logic [1:0]    comp_mode_i = '0;
    logic          valid_o;
    logic [1:0]    sel_code_o;
    logic [7:0]    red_idx_o, grn_idx_o, blu_idx_o;

    pixsel_unpack #(.MAX_SLOTS(NS)) dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        bit       v;
        bit [1:0] s;
        bit [7:0] r, g, b;
        string    req;
    } exp_t;

    exp_t  expq [int];
    int    edge_n = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string idle_req = "R11";

    always @(posedge clk) edge_n <= edge_n + 1;

    function automatic exp_t ref_pixel(logic [159:0] w, int k, int mode, int pm, int om,
                                       int comp, bit sb, int ovl, bit bn, string req);
        exp_t e;
        int size, steer, p, h, hit;
        logic [31:0] x;
        bit pick_p;
        e.v = 1; e.req = req; e.r = 0; e.g = 0; e.b = 0;
        size  = mode & 3;
        steer = (mode >> 5) & 3;
        hit   = ((ovl >> (2*k)) & 3) & om;
        if (!bn || size == 3) begin
            e.s = 3;
            return e;
        end
        if (hit != 0) begin
            e.s = 2; e.r = 8'(hit); e.g = 8'(hit); e.b = 8'(hit);
            return e;
        end
        if (size == 1) begin
            p = int'((w >> (8*k)) & 160'hff) & pm;
            e.s = 1; e.r = 8'(p); e.g = 8'(p); e.b = 8'(p);
        end else if (size == 2) begin
            h = int'((w >> (16*k)) & 160'hffff);
            e.s = 0;
            e.r = 8'(((h >> 10) & 63) * 4);
            e.g = 8'(((h >> 4) & 63) * 4);
            e.b = 8'((h & 15) * 16);
        end else begin
            x = 32'(w >> (32*k));
            p = int'((x >> (8*steer)) & 32'hff) & pm;
            case (comp)
                0: pick_p = sb && p != 0;
                1: pick_p = p != 0;
                2: pick_p = sb;
                default: pick_p = 1;
            endcase
            if (pick_p) begin
                e.s = 1; e.r = 8'(p); e.g = 8'(p); e.b = 8'(p);
            end else begin
                e.s = 0; e.r = x[31:24]; e.g = x[23:16]; e.b = x[15:8];
            end
        end
        return e;
    endfunction

    task automatic check_now();
        exp_t e;
        if (expq.exists(edge_n)) e = expq[edge_n];
        else begin
            e.v = 0; e.s = 3; e.r = 0; e.g = 0; e.b = 0; e.req = idle_req;
        end
        n_checks++;
        if (valid_o !== e.v || sel_code_o !== e.s || red_idx_o !== e.r ||
            grn_idx_o !== e.g || blu_idx_o !== e.b) begin
            n_fail++;
            $display("FAIL %s edge %0d: got v=%0d sel=%0d r=%h g=%h b=%h, expected v=%0d sel=%0d r=%h g=%h b=%h",
                     e.req, edge_n, valid_o, sel_code_o, red_idx_o, grn_idx_o, blu_idx_o,
                     e.v, e.s, e.r, e.g, e.b);
        end
    endtask

    task automatic scramble();
        load_i        = 0;
        pix_word_i    = {$urandom, $urandom, $urandom, $urandom, $urandom};
        pix_sel_i     = 5'($urandom);
        ovl_i         = 10'($urandom);
        blank_n_i     = 1'($urandom);
        mode_i        = 7'($urandom);
        pseudo_mask_i = 8'($urandom);
        ovl_mask_i    = 2'($urandom);
        comp_mode_i   = 2'($urandom);
    endtask

    task automatic tick();
        @(negedge clk);
        if (edge_n > 0) check_now();
    endtask

    task automatic send(logic [159:0] w, logic [4:0] sb, logic [9:0] ov, bit bn,
                        int mode, int pm, int om, int comp, int gap, string req);
        int c, f;
        tick();
        c = edge_n + 1;
        for (int k = c + 1; k <= c + NS + 2; k++)
            if (expq.exists(k)) expq.delete(k);
        f = (mode >> 2) & 7;
        if (f < 2) f = 2;
        if (f > NS) f = NS;
        for (int j = 0; j < f; j++)
            expq[c + 1 + j] = ref_pixel(w, j, mode, pm, om, comp, sb[j], int'(ov), bn, req);
        load_i = 1; pix_word_i = w; pix_sel_i = sb; ovl_i = ov; blank_n_i = bn;
        mode_i = 7'(mode); pseudo_mask_i = 8'(pm); ovl_mask_i = 2'(om); comp_mode_i = 2'(comp);
        for (int i = 1; i < gap; i++) begin
            tick();
            scramble();
        end
        tick();
        scramble();
    endtask

    function automatic int md(int size, int fac, int steer);
        return (steer << 5) | (fac << 2) | size;
    endfunction

    function automatic logic [159:0] rword();
        return {$urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        // R11: reset state, checked while reset is held and just after
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        tick(); tick();
        idle_req = "R1";

        // R3: 16-bit unpack with several fixed patterns
        send({5{32'hFFFF_0000}}, 5'h00, 10'h0, 1, md(2, 4, 0), 8'hff, 0, 3, 6, "R3");
        send({5{32'h8421_F00F}}, 5'h1f, 10'h0, 1, md(2, 5, 0), 8'hff, 0, 1, 7, "R3");
        send(rword(), 5'h00, 10'h0, 1, md(2, 5, 0), 8'h00, 0, 0, 7, "R3");

        // R7: 8-bit always pseudo; 16-bit always RGB whatever the compositing mode
        send(160'h00_01_80_7f_ff, 5'h00, 10'h0, 1, md(1, 5, 0), 8'hff, 0, 0, 7, "R7");
        send(rword(), 5'h00, 10'h0, 1, md(1, 3, 2), 8'hff, 0, 2, 5, "R7");
        send(rword(), 5'h1f, 10'h0, 1, md(2, 4, 0), 8'hff, 0, 3, 6, "R7");

        // R4: 32-bit layout and each pseudo-byte steering code
        for (int s = 0; s < 4; s++)
            send(rword(), 5'h1f, 10'h0, 1, md(0, 5, s), 8'hff, 0, 3, 7, "R4");
        send(rword(), 5'h00, 10'h0, 1, md(0, 5, 1), 8'hff, 0, 2, 7, "R4");

        // R5: pseudo mask applied before use and before the zero test
        send({5{32'h1234_56f0}}, 5'h1f, 10'h0, 1, md(0, 4, 0), 8'h0f, 0, 1, 6, "R5");
        send({5{32'h1234_5605}}, 5'h1f, 10'h0, 1, md(0, 4, 0), 8'h0f, 0, 3, 6, "R5");
        send(rword(), 5'h00, 10'h0, 1, md(1, 5, 0), 8'h3c, 0, 0, 7, "R5");

        // R6: every compositing mode against select pins and zero/non-zero pseudo
        for (int cm = 0; cm < 4; cm++) begin
            send({32'hAABBCC00, 32'hAABBCC11, 32'hAABBCC00, 32'hAABBCC22, 32'hAABBCC00},
                 5'b10101, 10'h0, 1, md(0, 5, 0), 8'hff, 0, cm, 7, "R6");
            send({32'hAABBCC11, 32'hAABBCC00, 32'hAABBCC33, 32'hAABBCC00, 32'hAABBCC44},
                 5'b01011, 10'h0, 1, md(0, 5, 0), 8'hff, 0, cm, 7, "R6");
        end

        // R8: overlay masking in all sizes
        for (int om = 0; om < 4; om++) begin
            send(rword(), 5'h1f, 10'b11_10_01_00_11, 1, md(0, 5, 0), 8'hff, om, 1, 7, "R8");
            send(rword(), 5'h00, 10'b00_11_10_01_10, 1, md(1, 5, 0), 8'hff, om, 0, 7, "R8");
            send(rword(), 5'h00, 10'b01_01_11_10_00, 1, md(2, 5, 0), 8'hff, om, 0, 7, "R8");
        end

        // R9: blank overrides pixel and overlay
        send(rword(), 5'h1f, 10'h3ff, 0, md(0, 5, 0), 8'hff, 3, 3, 7, "R9");
        send(rword(), 5'h00, 10'h000, 0, md(1, 3, 0), 8'hff, 0, 0, 5, "R9");

        // R10: reserved size
        send(rword(), 5'h1f, 10'h3ff, 1, md(3, 4, 0), 8'hff, 3, 3, 6, "R10");

        // R1: slot-count field clamping and idle after the last slot
        send(rword(), 5'h00, 10'h0, 1, md(1, 0, 0), 8'hff, 0, 0, 5, "R1");
        send(rword(), 5'h00, 10'h0, 1, md(1, 1, 0), 8'hff, 0, 0, 5, "R1");
        send(rword(), 5'h00, 10'h0, 1, md(2, 6, 0), 8'hff, 0, 0, 8, "R1");
        send(rword(), 5'h00, 10'h0, 1, md(0, 7, 2), 8'hff, 0, 3, 8, "R1");
        send(rword(), 5'h00, 10'h0, 1, md(1, 2, 0), 8'hff, 0, 0, 4, "R1");

        // R2: loads arriving before all slots are out
        for (int i = 0; i < 6; i++)
            send(rword(), 5'($urandom), 10'($urandom), 1, md(0, 4, i % 4), 8'hff, 2, i % 4, 2, "R2");
        send(rword(), 5'h00, 10'h0, 1, md(1, 5, 0), 8'hff, 0, 0, 1, "R2");
        send(rword(), 5'h00, 10'h0, 1, md(1, 5, 0), 8'hff, 0, 0, 7, "R2");

        // R12: controls scrambled between loads must not disturb the loaded word
        for (int i = 0; i < 8; i++)
            send(rword(), 5'($urandom), 10'($urandom), 1, md(i % 3, 5, i % 4),
                 int'($urandom % 256), int'($urandom % 4), int'($urandom % 4), 6, "R12");

        // Random mix of everything with random gaps (R2 timing under load)
        for (int i = 0; i < 400; i++)
            send(rword(), 5'($urandom), 10'($urandom), 1'($urandom % 8 != 0),
                 int'($urandom % 128), int'($urandom % 256), int'($urandom % 4),
                 int'($urandom % 4), 1 + int'($urandom % 7), "R2");

        for (int i = 0; i < 8; i++) tick();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule